// File: doc/BRIEF.md
# SDIO Extended Read/Write Command Decoder

This block sits on the card side of an SDIO interface and interprets the 32-bit argument of the extended read/write command (CMD53). When the command path raises a one-cycle strobe, the block splits the argument into its fields. It checks the requested function against the number of I/O functions that the card advertises in its operating-conditions word. In block mode it also checks the block length of the chosen function. It then either loads a transfer descriptor for the data-line engine or rejects the command. The descriptor carries direction, function, register address, address-increment flag, block mode, unit length, unit count and an endless flag.

The block always answers a command with a response-type code and an address-error flag. These go to the response serializer one cycle after the strobe. A two-state machine tracks the card: COMMAND (`CS_CMD`) and TRANSFER (`CS_XFER`). The transitions are ACCEPT (COMMAND or TRANSFER to TRANSFER on a command that decodes cleanly) and FINISH (TRANSFER to COMMAND when the data engine signals the end of a transfer). A rejected command leaves the state where it was. FINISH never fires in a cycle that also carries a command.

Top module: `sdio_ext_cmd_decoder`

## Requirements
- R1: Argument bit 31 sets the descriptor direction: 1 gives `xfer_write`=1, 0 gives `xfer_write`=0.
- R2: On an accepted command, `xfer_func` takes argument bits 30:28, `xfer_incr` takes bit 26, and `xfer_addr` takes bits 25:9.
- R3: With argument bit 27 clear (byte mode), `xfer_unit_len` is 1 and `xfer_endless` is 0. `xfer_units` is argument bits 8:0, or 512 when that field is zero. The block-length table has no effect in this mode.
- R4: With argument bit 27 set (block mode), `xfer_unit_len` is the selected function's entry of `blk_len_tbl` (entry f at bits 12f+11:12f). `xfer_units` is bits 8:0. A zero count gives `xfer_units`=0 with `xfer_endless`=1.
- R5: A block-mode command whose selected block length is 0 or above 2048 answers with `rsp_type`=1 (R1 type) and `addr_err`=0. It leaves the descriptor and the card state unchanged.
- R6: A command whose function number exceeds `io_ocr` bits 30:28 answers with `rsp_type`=2 (R5 type) and `addr_err`=1. It leaves the descriptor and the card state unchanged. This check takes priority over the block-length check.
- R7: A command that passes both checks loads the descriptor, sets `card_state` to 1 (TRANSFER), and answers with `rsp_type`=2 and `addr_err`=0.
- R8: `rsp_vld` is 1 in exactly the cycle after each `cmd_vld` cycle. `rsp_type` and `addr_err` hold their values until the next response.
- R9: `xfer_end` in TRANSFER with no command in the same cycle returns `card_state` to 0 (COMMAND) one cycle later. When a command arrives in the same cycle, the command's outcome decides the state. In COMMAND, `xfer_end` has no effect.
- R10: After reset, `card_state`=0, `rsp_vld`=0, `rsp_type`=0, `addr_err`=0 and every descriptor output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_vld | input | 1 | One-cycle strobe: a CMD53 argument is present |
| cmd_arg | input | 32 | Command argument word |
| io_ocr | input | 32 | Card I/O operating-conditions word; bits 30:28 give the function count |
| blk_len_tbl | input | 96 | Eight 12-bit per-function block lengths, function f at bits 12f+11:12f |
| xfer_end | input | 1 | Data engine reports the transfer has ended |
| xfer_write | output | 1 | Descriptor: 1 = write, 0 = read |
| xfer_func | output | 3 | Descriptor: function number |
| xfer_addr | output | 17 | Descriptor: start register address |
| xfer_incr | output | 1 | Descriptor: address increments per byte |
| xfer_blk_mode | output | 1 | Descriptor: block mode |
| xfer_unit_len | output | 12 | Descriptor: bytes per unit |
| xfer_units | output | 10 | Descriptor: number of units |
| xfer_endless | output | 1 | Descriptor: transfer runs until stopped |
| card_state | output | 1 | 0 = COMMAND, 1 = TRANSFER |
| rsp_vld | output | 1 | Response code valid this cycle |
| rsp_type | output | 2 | 0 none, 1 R1 type, 2 R5 type |
| addr_err | output | 1 | Address-error status for the last response |

## Verification
The interesting overlap is a new command landing in the same cycle as the data engine's end-of-transfer report. The FINISH transition and the ACCEPT or reject outcome then compete for the state register. The bench provokes this both with directed cases and with random `xfer_end` pulses that are independent of `cmd_vld`. It judges the result against a reference model in which the command alone decides the next state. A second overlap is a command that fails both the function check and the block-length check. There the model requires the address-error answer to win.

// File: rtl/sdx_pkg.sv
package sdx_pkg;
    typedef enum logic [1:0] {
        RSP_NONE = 2'd0,
        RSP_R1   = 2'd1,
        RSP_R5   = 2'd2
    } rsp_e;

    typedef enum logic {
        CS_CMD  = 1'b0,
        CS_XFER = 1'b1
    } card_st_e;
endpackage

// File: rtl/sdx_arg_decode.sv
module sdx_arg_decode #(
    parameter int FUNC_W   = 3,
    parameter int ADDR_W   = 17,
    parameter int CNT_W    = 9,
    parameter int BLEN_W   = 12,
    parameter int MAX_BLEN = 2048
) (
    input  logic [31:0]                     arg,
    input  logic [31:0]                     ocr,
    input  logic [(1<<FUNC_W)*BLEN_W-1:0]   blen_tbl,
    output logic                            d_write,
    output logic [FUNC_W-1:0]               d_func,
    output logic [ADDR_W-1:0]               d_addr,
    output logic                            d_incr,
    output logic                            d_blk,
    output logic [BLEN_W-1:0]               d_unit_len,
    output logic [CNT_W:0]                  d_units,
    output logic                            d_endless,
    output logic                            func_bad,
    output logic                            blen_bad
);
    localparam int DIR_BIT  = 31;
    localparam int FUNC_LSB = 28;
    localparam int BLK_BIT  = 27;
    localparam int INC_BIT  = 26;
    localparam int ADDR_LSB = 9;
    localparam int UNITS_W  = CNT_W + 1;
    localparam logic [BLEN_W-1:0]  MAX_B     = BLEN_W'(MAX_BLEN);
    localparam logic [UNITS_W-1:0] FULL_CNT  = UNITS_W'(1) << CNT_W;

    logic [CNT_W-1:0]  cnt;
    logic [BLEN_W-1:0] sel_blen;
    logic [FUNC_W-1:0] func_cnt;

    always_comb begin
        d_write  = arg[DIR_BIT];
        d_func   = arg[FUNC_LSB +: FUNC_W];
        d_blk    = arg[BLK_BIT];
        d_incr   = arg[INC_BIT];
        d_addr   = arg[ADDR_LSB +: ADDR_W];
        cnt      = arg[CNT_W-1:0];
        func_cnt = ocr[FUNC_LSB +: FUNC_W];
        sel_blen = blen_tbl[d_func*BLEN_W +: BLEN_W];

        func_bad = (d_func > func_cnt);
        blen_bad = d_blk && ((sel_blen == '0) || (sel_blen > MAX_B));

        d_unit_len = d_blk ? sel_blen : BLEN_W'(1);
        d_endless  = d_blk && (cnt == '0);
        if (cnt != '0)
            d_units = {1'b0, cnt};
        else if (d_blk)
            d_units = '0;
        else
            d_units = FULL_CNT;
    end
endmodule

// File: rtl/sdx_state_fsm.sv
module sdx_state_fsm
    import sdx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cmd_vld,
    input  logic     func_bad,
    input  logic     blen_bad,
    input  logic     xfer_end,
    output logic     load,
    output card_st_e state_q,
    output logic     rsp_vld,
    output rsp_e     rsp_type,
    output logic     addr_err
);
    card_st_e state_d;

    assign load = cmd_vld && !func_bad && !blen_bad;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CS_CMD:  if (load) state_d = CS_XFER;
            CS_XFER: if (!cmd_vld && xfer_end) state_d = CS_CMD;
            default: state_d = CS_CMD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CS_CMD;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_vld  <= 1'b0;
            rsp_type <= RSP_NONE;
            addr_err <= 1'b0;
        end else if (cmd_vld) begin
            rsp_vld  <= 1'b1;
            addr_err <= func_bad;
            if (func_bad)      rsp_type <= RSP_R5;
            else if (blen_bad) rsp_type <= RSP_R1;
            else               rsp_type <= RSP_R5;
        end else begin
            rsp_vld  <= 1'b0;
        end
    end

    // R8
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_vld |=> rsp_vld);
    // R8
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_vld |=> !rsp_vld && $stable(rsp_type) && $stable(addr_err));
    // R6
    func_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_vld && func_bad |=> addr_err && rsp_type == RSP_R5 && $stable(state_q));
    // R7
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> state_q == CS_XFER && rsp_type == RSP_R5 && !addr_err);
    // R9
    finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == CS_XFER && xfer_end && !cmd_vld |=> state_q == CS_CMD);
endmodule

// File: rtl/sdio_ext_cmd_decoder.sv
module sdio_ext_cmd_decoder
    import sdx_pkg::*;
#(
    parameter int FUNC_W   = 3,
    parameter int ADDR_W   = 17,
    parameter int CNT_W    = 9,
    parameter int BLEN_W   = 12,
    parameter int MAX_BLEN = 2048
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cmd_vld,
    input  logic [31:0]                     cmd_arg,
    input  logic [31:0]                     io_ocr,
    input  logic [(1<<FUNC_W)*BLEN_W-1:0]   blk_len_tbl,
    input  logic                            xfer_end,
    output logic                            xfer_write,
    output logic [FUNC_W-1:0]               xfer_func,
    output logic [ADDR_W-1:0]               xfer_addr,
    output logic                            xfer_incr,
    output logic                            xfer_blk_mode,
    output logic [BLEN_W-1:0]               xfer_unit_len,
    output logic [CNT_W:0]                  xfer_units,
    output logic                            xfer_endless,
    output logic                            card_state,
    output logic                            rsp_vld,
    output logic [1:0]                      rsp_type,
    output logic                            addr_err
);
    logic              d_write, d_incr, d_blk, d_endless, func_bad, blen_bad, load;
    logic [FUNC_W-1:0] d_func;
    logic [ADDR_W-1:0] d_addr;
    logic [BLEN_W-1:0] d_unit_len;
    logic [CNT_W:0]    d_units;
    card_st_e          st;
    rsp_e              rsp;

    sdx_arg_decode #(
        .FUNC_W(FUNC_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
        .BLEN_W(BLEN_W), .MAX_BLEN(MAX_BLEN)
    ) u_dec (
        .arg(cmd_arg), .ocr(io_ocr), .blen_tbl(blk_len_tbl),
        .d_write(d_write), .d_func(d_func), .d_addr(d_addr), .d_incr(d_incr),
        .d_blk(d_blk), .d_unit_len(d_unit_len), .d_units(d_units),
        .d_endless(d_endless), .func_bad(func_bad), .blen_bad(blen_bad)
    );

    sdx_state_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .func_bad(func_bad),
        .blen_bad(blen_bad), .xfer_end(xfer_end), .load(load),
        .state_q(st), .rsp_vld(rsp_vld), .rsp_type(rsp), .addr_err(addr_err)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xfer_write    <= 1'b0;
            xfer_func     <= '0;
            xfer_addr     <= '0;
            xfer_incr     <= 1'b0;
            xfer_blk_mode <= 1'b0;
            xfer_unit_len <= '0;
            xfer_units    <= '0;
            xfer_endless  <= 1'b0;
        end else if (load) begin
            xfer_write    <= d_write;
            xfer_func     <= d_func;
            xfer_addr     <= d_addr;
            xfer_incr     <= d_incr;
            xfer_blk_mode <= d_blk;
            xfer_unit_len <= d_unit_len;
            xfer_units    <= d_units;
            xfer_endless  <= d_endless;
        end
    end

    assign card_state = st;
    assign rsp_type   = rsp;

    // R5
    blen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_vld && blen_bad && !func_bad |=> rsp_type == 2'd1 && !addr_err
            && $stable(xfer_unit_len) && $stable(xfer_units) && $stable(xfer_func));
    // R4
    endless_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_endless |-> xfer_blk_mode && xfer_units == '0);
endmodule

// File: tb/tb_sdio_ext_cmd_decoder.sv
`timescale 1ns/1ps
module tb_sdio_ext_cmd_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_vld = 1'b0;
    logic [31:0] cmd_arg = '0;
    logic [31:0] io_ocr = '0;
    logic [95:0] blk_len_tbl = '0;
    logic        xfer_end = 1'b0;
    logic        xfer_write, xfer_incr, xfer_blk_mode, xfer_endless;
    logic [2:0]  xfer_func;
    logic [16:0] xfer_addr;
    logic [11:0] xfer_unit_len;
    logic [9:0]  xfer_units;
    logic        card_state, rsp_vld, addr_err;
    logic [1:0]  rsp_type;

    int n_chk = 0;
    int n_bad = 0;

    // expected model
    logic        m_w, m_inc, m_blk, m_end, m_st, m_rv, m_err;
    logic [2:0]  m_f;
    logic [16:0] m_a;
    logic [11:0] m_ul;
    logic [9:0]  m_u;
    logic [1:0]  m_rt;

    always #4 clk = ~clk;

    sdio_ext_cmd_decoder dut (
        .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_arg(cmd_arg),
        .io_ocr(io_ocr), .blk_len_tbl(blk_len_tbl), .xfer_end(xfer_end),
        .xfer_write(xfer_write), .xfer_func(xfer_func), .xfer_addr(xfer_addr),
        .xfer_incr(xfer_incr), .xfer_blk_mode(xfer_blk_mode),
        .xfer_unit_len(xfer_unit_len), .xfer_units(xfer_units),
        .xfer_endless(xfer_endless), .card_state(card_state), .rsp_vld(rsp_vld),
        .rsp_type(rsp_type), .addr_err(addr_err)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic w, input logic [2:0] f, input logic blk,
                                       input logic inc, input logic [16:0] a, input logic [8:0] c);
        return {w, f, blk, inc, a, c};
    endfunction

    function automatic logic [31:0] ocr_of(input logic [2:0] n);
        return {1'b0, n, 28'h0};
    endfunction

    task automatic model(input logic v, input logic [31:0] a, input logic [31:0] o,
                         input logic [95:0] t, input logic e);
        logic [2:0]  f;
        logic [11:0] bl;
        f  = a[30:28];
        bl = t[f*12 +: 12];
        if (v) begin
            m_rv = 1'b1;
            if (f > o[30:28]) begin
                m_err = 1'b1; m_rt = 2'd2;
            end else if (a[27] && (bl == 0 || bl > 12'd2048)) begin
                m_err = 1'b0; m_rt = 2'd1;
            end else begin
                m_err = 1'b0; m_rt = 2'd2; m_st = 1'b1;
                m_w = a[31]; m_f = f; m_blk = a[27]; m_inc = a[26]; m_a = a[25:9];
                m_ul = a[27] ? bl : 12'd1;
                m_end = a[27] && (a[8:0] == 0);
                m_u = (a[8:0] != 0) ? {1'b0, a[8:0]} : (a[27] ? 10'd0 : 10'd512);
            end
        end else begin
            m_rv = 1'b0;
            if (m_st && e) m_st = 1'b0;
        end
    endtask

    task automatic check_all();
        string tu;
        string tr;
        tu = m_blk ? "R4" : "R3";
        tr = (m_rt == 2'd1) ? "R5" : (m_err ? "R6" : "R7");
        chk("R1", "xfer_write", int'(xfer_write), int'(m_w));
        chk("R2", "xfer_func", int'(xfer_func), int'(m_f));
        chk("R2", "xfer_addr", int'(xfer_addr), int'(m_a));
        chk("R2", "xfer_incr", int'(xfer_incr), int'(m_inc));
        chk(tu, "xfer_blk_mode", int'(xfer_blk_mode), int'(m_blk));
        chk(tu, "xfer_unit_len", int'(xfer_unit_len), int'(m_ul));
        chk(tu, "xfer_units", int'(xfer_units), int'(m_u));
        chk(tu, "xfer_endless", int'(xfer_endless), int'(m_end));
        chk("R8", "rsp_vld", int'(rsp_vld), int'(m_rv));
        chk(tr, "rsp_type", int'(rsp_type), int'(m_rt));
        chk(tr, "addr_err", int'(addr_err), int'(m_err));
        chk("R9", "card_state", int'(card_state), int'(m_st));
    endtask

    // drive at negedge, sample at the following negedge
    task automatic step(input logic v, input logic [31:0] a, input logic [31:0] o,
                        input logic [95:0] t, input logic e);
        cmd_vld = v; cmd_arg = a; io_ocr = o; blk_len_tbl = t; xfer_end = e;
        model(v, a, o, t, e);
        @(negedge clk);
        check_all();
    endtask

    function automatic logic [95:0] rand_tbl();
        logic [95:0] t;
        for (int i = 0; i < 8; i++) begin
            int r;
            r = $urandom_range(0, 9);
            if (r == 0)      t[i*12 +: 12] = 12'd0;
            else if (r == 1) t[i*12 +: 12] = 12'(2049 + $urandom_range(0, 2046));
            else if (r == 2) t[i*12 +: 12] = 12'd2048;
            else             t[i*12 +: 12] = 12'($urandom_range(1, 2047));
        end
        return t;
    endfunction

    logic [95:0] tb_tbl;

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        m_w = 0; m_inc = 0; m_blk = 0; m_end = 0; m_st = 0; m_rv = 0; m_err = 0;
        m_f = 0; m_a = 0; m_ul = 0; m_u = 0; m_rt = 0;
        repeat (3) @(negedge clk);
        // R10 reset state
        check_all();
        chk("R10", "reset card_state", int'(card_state), 0);
        rst_n = 1'b1;

        tb_tbl = '0;
        tb_tbl[0*12 +: 12] = 12'd2048;
        tb_tbl[1*12 +: 12] = 12'd2049;
        tb_tbl[2*12 +: 12] = 12'd0;
        tb_tbl[3*12 +: 12] = 12'd1;
        tb_tbl[4*12 +: 12] = 12'd64;

        // R9 end in COMMAND state is ignored
        step(1'b0, '0, ocr_of(3'd7), tb_tbl, 1'b1);
        // R3 byte mode count zero -> 512, bad table entry ignored
        step(1'b1, mk(1'b1, 3'd1, 1'b0, 1'b1, 17'h1ABCD, 9'd0), ocr_of(3'd7), tb_tbl, 1'b0);
        step(1'b0, '0, ocr_of(3'd7), tb_tbl, 1'b0);
        // R4 block mode count zero -> endless, length 2048 accepted
        step(1'b1, mk(1'b0, 3'd0, 1'b1, 1'b0, 17'h00042, 9'd0), ocr_of(3'd7), tb_tbl, 1'b0);
        // R5 length 2049 rejected, length 0 rejected
        step(1'b1, mk(1'b1, 3'd1, 1'b1, 1'b1, 17'h00001, 9'd5), ocr_of(3'd7), tb_tbl, 1'b0);
        step(1'b1, mk(1'b1, 3'd2, 1'b1, 1'b1, 17'h00002, 9'd5), ocr_of(3'd7), tb_tbl, 1'b0);
        // R9 end alone leaves TRANSFER
        step(1'b0, '0, ocr_of(3'd7), tb_tbl, 1'b1);
        // R6 function equal to count accepted, one above rejected even with bad length
        step(1'b1, mk(1'b0, 3'd3, 1'b1, 1'b0, 17'h10000, 9'd511), ocr_of(3'd3), tb_tbl, 1'b0);
        step(1'b1, mk(1'b0, 3'd2, 1'b1, 1'b0, 17'h00003, 9'd1), ocr_of(3'd1), tb_tbl, 1'b0);
        // R9 command and end in the same cycle: command decides
        step(1'b1, mk(1'b1, 3'd4, 1'b1, 1'b1, 17'h0FFFF, 9'd3), ocr_of(3'd4), tb_tbl, 1'b1);
        step(1'b1, mk(1'b1, 3'd5, 1'b0, 1'b1, 17'h00010, 9'd7), ocr_of(3'd4), tb_tbl, 1'b1);
        step(1'b0, '0, ocr_of(3'd4), tb_tbl, 1'b1);
        // R5 rejected in COMMAND state stays in COMMAND
        step(1'b1, mk(1'b0, 3'd2, 1'b1, 1'b0, 17'h00005, 9'd2), ocr_of(3'd7), tb_tbl, 1'b0);

        // random stimulus
        for (int i = 0; i < 600; i++) begin
            logic v;
            logic e;
            logic [31:0] a;
            v = ($urandom_range(0, 2) != 0);
            e = ($urandom_range(0, 4) == 0);
            a = $urandom;
            if ($urandom_range(0, 5) == 0) a[8:0] = 9'd0;
            step(v, a, ocr_of(3'($urandom_range(0, 7))), rand_tbl(), e);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule